// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from a table that sits in memory. The address is split three ways. The top ten bits index an outer table whose start comes from a base-register input. The outer entry gives the start of an inner table. The next ten bits index that inner table. The inner entry supplies the frame number, and the low twelve bits pass through unchanged as the offset within a 4 KB page.

A requester hands over one address with a valid/ready handshake. The walker issues its reads one at a time on a simple read port: a single-cycle read strobe with an address, answered later by a one-cycle data-valid pulse. It then presents either the physical address or a page-fault flag. If either entry has its valid bit clear, the walk stops at that level and reports a fault. The response stays on the outputs until the requester acknowledges it, and only then is a new address taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd is 0.
- R2: The first read after a request is accepted has address pt_base + vaddr[31:22]*4.
- R3: When the outer entry is valid (bit 0 = 1), the second read has address {outer[31:12], 12'h000} + vaddr[21:12]*4.
- R4: When the inner entry is valid, the response has rsp_fault = 0 and rsp_paddr = {inner[31:12], vaddr[11:0]}.
- R5: An outer entry with bit 0 = 0 ends the walk after that single read, with rsp_fault = 1 and rsp_paddr = 0.
- R6: An inner entry with bit 0 = 0 gives rsp_fault = 1 and rsp_paddr = 0, after exactly two reads.
- R7: At most one read is outstanding: mem_rd is not asserted again before the data for the previous read has returned.
- R8: A request is taken only while the walker is idle. While a walk or a response is pending, req_ready is 0 and a presented req_vaddr has no effect on the result.
- R9: rsp_valid, rsp_paddr and rsp_fault hold steady until rsp_ack is seen. rsp_valid falls, and req_ready rises, in the cycle after the acknowledge.
- R10: Entry bits 11:1 (bit 1 being the writable flag) do not change the read addresses or the translated address.
- R11: A mem_rvalid pulse while no read is outstanding is ignored: no response and no read follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | 32 | Byte address of the outer table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ack | input | 1 | Requester has taken the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault: an entry was invalid |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data (table entry) |

## Verification
The hardest case to set up is a second request that arrives while a walk is in flight. The bench holds a different address on the request port during the read latency and through the held response. It then checks that the result and the read addresses still belong to the first request. The bench memory model counts any read strobe issued while a read is outstanding. The model can also drive a stray data-valid pulse while the walker is idle, which shows that data arriving with no read outstanding is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int ESZ_LOG2 = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER,
    ST_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int AW       = 32,
  parameter int IDX_W    = 10,
  parameter int ESZ_LOG2 = 2
) (
  input  logic [AW-1:0]    tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    ent_addr
);
  logic [AW-1:0] idx_ext;

  assign idx_ext  = AW'(idx);
  assign ent_addr = tbl_base + (idx_ext << ESZ_LOG2);
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int PW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [PW-1:0]       ent,
  output logic                ent_ok,
  output logic [PW-OFF_W-1:0] ent_frame
);
  logic unused_attr;

  assign ent_ok      = ent[0];
  assign ent_frame   = ent[PW-1:OFF_W];
  assign unused_attr = ^ent[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int P_VA_W  = VA_W,
  parameter int P_OFF_W = OFF_W,
  parameter int P_IDX_W = IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [P_VA_W-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [P_VA_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ack,
  output logic [P_VA_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_rd,
  output logic [P_VA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [P_VA_W-1:0] mem_rdata
);
  localparam int FRM_W  = P_VA_W - P_OFF_W;
  localparam int OUT_LO = P_OFF_W + P_IDX_W;

  walk_st_e          state_q;
  logic [P_VA_W-1:0] vaddr_q;
  logic [P_VA_W-1:0] ag_base;
  logic [P_IDX_W-1:0] ag_idx;
  logic [P_VA_W-1:0] ag_addr;
  logic              ent_ok;
  logic [FRM_W-1:0]  ent_frame;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    if (state_q == ST_IDLE) begin
      ag_base = pt_base;
      ag_idx  = req_vaddr[OUT_LO +: P_IDX_W];
    end else begin
      ag_base = {ent_frame, {P_OFF_W{1'b0}}};
      ag_idx  = vaddr_q[P_OFF_W +: P_IDX_W];
    end
  end

  ptw_entry_addr #(.AW(P_VA_W), .IDX_W(P_IDX_W), .ESZ_LOG2(ESZ_LOG2)) u_addr (
    .tbl_base (ag_base),
    .idx      (ag_idx),
    .ent_addr (ag_addr)
  );

  ptw_entry_dec #(.PW(P_VA_W), .OFF_W(P_OFF_W)) u_dec (
    .ent       (mem_rdata),
    .ent_ok    (ent_ok),
    .ent_frame (ent_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      mem_rd <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr;
            mem_rd   <= 1'b1;
            mem_addr <= ag_addr;
            state_q  <= ST_OUTER;
          end
        end
        ST_OUTER: begin
          if (mem_rvalid) begin
            if (ent_ok) begin
              mem_rd   <= 1'b1;
              mem_addr <= ag_addr;
              state_q  <= ST_INNER;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              state_q   <= ST_FAULT;
            end
          end
        end
        ST_INNER: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            if (ent_ok) begin
              rsp_fault <= 1'b0;
              rsp_paddr <= {ent_frame, vaddr_q[P_OFF_W-1:0]};
              state_q   <= ST_DONE;
            end else begin
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              state_q   <= ST_FAULT;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (rsp_ack) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  single_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R5
  outer_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OUTER && mem_rvalid && !mem_rdata[0])
    |=> (rsp_valid && rsp_fault && !mem_rd));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INNER && mem_rvalid && mem_rdata[0])
    |=> (rsp_valid && !rsp_fault && rsp_paddr[P_OFF_W-1:0] == vaddr_q[P_OFF_W-1:0]));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ack) |=> (!rsp_valid && req_ready));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(vaddr_q));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pt_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ack = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] pmem [logic [31:0]];
  int lat = 1;
  int pend_cnt = 0;
  logic [31:0] pend_addr;
  int rd_cnt = 0;
  int overlap = 0;
  logic [31:0] rd_log [4];
  bit spur = 0;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (spur) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= 32'hDEAD_0001;
    end else if (mem_rd) begin
      if (pend_cnt > 0) overlap++;
      if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
      rd_cnt++;
      pend_addr = mem_addr;
      pend_cnt  = lat;
    end else if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pmem.exists(pend_addr) ? pmem[pend_addr] : 32'h0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ack_rsp();
    rsp_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(rsp_valid == 1'b0, "R9 valid drop", {31'b0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R9 ready back", {31'b0, req_ready}, 32'h1);
  endtask

  // One walk; poke=1 presents another address while busy (R8)
  task automatic run_walk(input logic [31:0] base, input logic [31:0] va,
                          input int hold, input bit poke,
                          input bit exp_fault, input logic [31:0] exp_pa,
                          input int exp_reads, input string tag);
    logic [31:0] a0;
    logic [31:0] a1;
    a0 = base + {20'b0, va[31:22], 2'b00};
    rd_cnt = 0;
    @(negedge clk);
    pt_base = base;
    req_vaddr = va;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      chk(req_ready == 1'b0, "R8 busy ready", {31'b0, req_ready}, 32'h0);
      req_vaddr = ~va;
      pt_base = base ^ 32'h0000_F000;
      req_valid = 1'b1;
    end
    while (!rsp_valid) @(negedge clk);
    if (poke) chk(req_ready == 1'b0, "R8 ready with response", {31'b0, req_ready}, 32'h0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == exp_pa && rsp_fault == exp_fault,
          {"R9 hold ", tag}, rsp_paddr, exp_pa);
    end
    if (poke) req_valid = 1'b0;
    chk(rsp_fault == exp_fault, {"fault ", tag}, {31'b0, rsp_fault}, {31'b0, exp_fault});
    chk(rsp_paddr == exp_pa, {"paddr ", tag}, rsp_paddr, exp_pa);
    chk(rd_cnt == exp_reads, {"read count ", tag}, rd_cnt, exp_reads);
    chk(rd_log[0] == a0, {"R2 outer addr ", tag}, rd_log[0], a0);
    if (exp_reads == 2) begin
      a1 = {pmem[a0][31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
      chk(rd_log[1] == a1, {"R3 inner addr ", tag}, rd_log[1], a1);
    end
    ack_rsp();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_rd == 1'b0, "R1 mem_rd", {31'b0, mem_rd}, 32'h0);
  endtask

  task automatic t_basic();
    lat = 1;
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0002_000C] = 32'h0ABC_D001;
    run_walk(32'h0001_0000, 32'h0040_3ABC, 0, 0, 0, 32'h0ABC_DABC, 2, "R4 basic");
  endtask

  task automatic t_attr_bits();
    lat = 3;
    pmem[32'h0030_0FFC] = 32'h0040_0FFF;
    pmem[32'h0040_0FFC] = 32'h1234_5FFF;
    run_walk(32'h0030_0000, 32'hFFFF_F123, 0, 0, 0, 32'h1234_5123, 2, "R10 attr bits max idx");
  endtask

  task automatic t_outer_fault();
    lat = 2;
    pmem[32'h0001_0008] = 32'h0005_0FFE;
    run_walk(32'h0001_0000, 32'h0080_0000, 0, 0, 1, 32'h0, 1, "R5 outer fault");
  endtask

  task automatic t_inner_fault();
    lat = 1;
    pmem[32'h0001_000C] = 32'h0006_0003;
    run_walk(32'h0001_0000, 32'h00C0_5000, 0, 0, 1, 32'h0, 2, "R6 inner fault");
  endtask

  task automatic t_busy();
    lat = 3;
    run_walk(32'h0001_0000, 32'h0040_3ABC, 2, 1, 0, 32'h0ABC_DABC, 2, "R8 busy request");
  endtask

  task automatic t_hold();
    lat = 1;
    run_walk(32'h0030_0000, 32'hFFFF_F123, 6, 0, 0, 32'h1234_5123, 2, "R9 held");
  endtask

  task automatic t_spurious();
    @(negedge clk);
    spur = 1'b1;
    @(posedge clk);
    @(negedge clk);
    spur = 1'b0;
    rd_cnt = 0;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1 && rd_cnt == 0, "R11 stray data",
          {30'b0, rsp_valid, req_ready}, 32'h1);
    end
    run_walk(32'h0001_0000, 32'h0040_3ABC, 0, 0, 0, 32'h0ABC_DABC, 2, "R11 after stray");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_attr_bits();
    t_outer_fault();
    t_inner_fault();
    t_busy();
    t_hold();
    t_spurious();
    chk(overlap == 0, "R7 overlapping reads", overlap, 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule